// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overwrite, Framing and Break Flags

This block receives 8-bit characters from an asynchronous serial line. A tick input pulses once per sixteenth of a bit period. The block uses it to find each start bit, confirm it at mid-bit, and sample every following bit at its centre. Each completed character goes into a receive buffer, and a ready flag is raised at the same time. Software reads the buffer and drops the ready flag with a dedicated clear strobe.

Three status flags report on the line. The overwrite flag records that a character arrived while the previous one was still unread. It stays set until software clears it with a write strobe. The framing flag reports a low stop bit and is recomputed at every character. The break flag reports that the line has been held low for at least 10.5 bit times (168 ticks). It is re-evaluated when each character completes. After a character whose stop bit was low, the receiver waits for the line to go high again before it looks for a new start bit. An optional parity slot, chosen by a parameter, is skipped without being checked.

Top module: `uart_rx_flags`

## Requirements
- R1: After a synchronous active-low reset, `rx_rdy`, `ovr_flag`, `frm_flag` and `brk_flag` are 0 and `rx_data` is 8'h00.
- R2: A start bit is taken only if the line is still low on the 8th tick after the tick that first saw it low. A low pulse of 8 ticks produces no character, and a low pulse of 9 ticks is accepted as a start bit.
- R3: Data bits are taken least significant bit first, one every 16 ticks. When the stop bit has been sampled, `rx_data` holds the character and `rx_rdy` rises in the same cycle.
- R4: A one-cycle pulse on `rdy_clr` drops `rx_rdy` when no character completes in that cycle.
- R5: If a character completes while `rx_rdy` is 1, `ovr_flag` becomes 1 and `rx_data` is replaced by the new character.
- R6: `ovr_flag` stays 1 across later characters until a one-cycle pulse on `ovr_wclr` (the write-zero strobe) clears it.
- R7: At each character, `frm_flag` takes the value 1 if the sampled stop bit was low and 0 if it was high. It does not change between characters.
- R8: `brk_flag` becomes 1 once the line has been sampled low on 168 consecutive ticks. A low stretch of 167 ticks leaves it at 0.
- R9: When a character completes after the line has been low for fewer than 168 consecutive ticks, `brk_flag` returns to 0.
- R10: After a character with a low stop bit, no new character is assembled until the line has returned high. A continuous low line yields exactly one character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| rdy_clr | input | 1 | Strobe that clears the ready flag |
| ovr_wclr | input | 1 | Strobe that writes 0 to the overwrite flag |
| rx_data | output | 8 | Most recently received character |
| rx_rdy | output | 1 | Character waiting to be read |
| ovr_flag | output | 1 | Sticky overwrite flag |
| frm_flag | output | 1 | Stop bit of the last character was low |
| brk_flag | output | 1 | Line held low for 168 or more ticks |

## Verification
The assertions check, on every cycle, the local rules of the flags. The ready flag only rises when a character is loaded, and a clear strobe drops it. The overwrite flag is sticky and is set by a completion while the ready flag is 1. The framing flag holds steady between characters. A rejected start returns the receiver to idle, and the receiver stays waiting while the line is low after a bad stop bit. The break counter's threshold pulse agrees with its saturation state. Only the bench scenarios can show that whole characters decode to the right byte, and that the 8-versus-9 tick glitch boundary and the 167-versus-168 tick break boundary fall exactly where specified. They also show that a long break yields a single character.

// File: rtl/uart_rx_flags_pkg.sv
// Package: shared types for the serial receiver.
// Assumes nothing beyond standard enum support.
package uart_rx_flags_pkg;

    // Receive sequencer states
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PAR    = 3'd3,
        S_STOP   = 3'd4,
        S_WAITHI = 3'd5
    } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
// Module: two-flop synchronizer for the asynchronous receive line.
// Assumes the line idles high, so both stages reset to 1.
module uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic meta;

    // Move the raw line into the clock domain through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= 1'b1;
            d_out <= 1'b1;
        end else begin
            meta  <= d_in;
            d_out <= meta;
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame sequencer. It hunts for a start bit, confirms it at mid-bit,
// shifts in eight data bits LSB first at bit centres, skips an optional
// parity slot and samples the stop bit. It pulses done for one cycle with
// the character and the stop value. After a low stop bit it waits for the
// line to go high. Assumes rx_s is already synchronized.
module uart_rx_frame #(
    parameter int OSR       = 16,
    parameter int DBITS     = 8,
    parameter bit PARITY_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_s,
    output logic             done,
    output logic [DBITS-1:0] data,
    output logic             stop_ok
);
    import uart_rx_flags_pkg::*;

    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DBITS);
    localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_T = CW'(OSR / 2 - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DBITS - 1);

    rx_state_t        st;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [DBITS-1:0] shreg;

    // Step the sequencer on each oversampling tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            data    <= '0;
            stop_ok <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    S_IDLE: begin
                        if (!rx_s) begin
                            st  <= S_START;
                            cnt <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == HALF_T) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST_T) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[DBITS-1:1]};
                            if (bitn == LAST_B) begin
                                st <= PARITY_EN ? S_PAR : S_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == LAST_T) begin
                            cnt <= '0;
                            st  <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST_T) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            data    <= shreg;
                            stop_ok <= rx_s;
                            st      <= rx_s ? S_IDLE : S_WAITHI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_WAITHI: begin
                        if (rx_s) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R2
    // glitch_reject_chk: a start that is high at mid-bit returns to idle
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_START && tick && cnt == HALF_T && rx_s) |=> (st == S_IDLE));

    // R3
    // done_from_stop_chk: a character completes only out of the stop slot
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == S_STOP));

    // R10
    // wait_high_chk: the receiver holds while the line stays low after a bad stop
    wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAITHI && !rx_s) |=> (st == S_WAITHI));
endmodule

// File: rtl/uart_rx_brk.sv
// Module: break detector. It counts consecutive low ticks on the line,
// saturating at the threshold. It reports a one-cycle hit when the
// threshold is reached and a level while the count sits there.
// Assumes rx_s is synchronized and the tick is one cycle wide.
module uart_rx_brk #(
    parameter int BRK_TICKS = 168
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_s,
    output logic hit,
    output logic long_low
);
    localparam int BW = $clog2(BRK_TICKS + 1);
    localparam logic [BW-1:0] LIM  = BW'(BRK_TICKS);
    localparam logic [BW-1:0] LIM1 = BW'(BRK_TICKS - 1);

    logic [BW-1:0] lcnt;

    // Count low ticks, restart on any high tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt <= '0;
            hit  <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (tick) begin
                if (rx_s) begin
                    lcnt <= '0;
                end else if (lcnt != LIM) begin
                    lcnt <= lcnt + 1'b1;
                    hit  <= (lcnt == LIM1);
                end
            end
        end
    end

    assign long_low = (lcnt == LIM);

    // R8
    // brk_hit_chk: the hit pulse coincides with reaching the threshold
    brk_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> long_low);

    // R9
    // brk_restart_chk: a high tick clears the accumulated low time
    brk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rx_s) |=> !long_low);
endmodule

// File: rtl/uart_rx_stat.sv
// Module: receive buffer and flags. It loads the character on done,
// keeps the ready, sticky overwrite, framing and break flags.
// Assumes done is a one-cycle pulse; a set on done wins over a clear.
module uart_rx_stat #(
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [DBITS-1:0] data,
    input  logic             stop_ok,
    input  logic             brk_hit,
    input  logic             long_low,
    input  logic             rdy_clr,
    input  logic             ovr_wclr,
    output logic [DBITS-1:0] buf_q,
    output logic             rdy,
    output logic             ovr,
    output logic             frm,
    output logic             brk
);
    // Load the buffer and maintain the ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            rdy   <= 1'b0;
        end else if (done) begin
            buf_q <= data;
            rdy   <= 1'b1;
        end else if (rdy_clr) begin
            rdy <= 1'b0;
        end
    end

    // Sticky overwrite flag, cleared only by the write-zero strobe
    always_ff @(posedge clk) begin
        if (!rst_n)            ovr <= 1'b0;
        else if (done && rdy)  ovr <= 1'b1;
        else if (ovr_wclr)     ovr <= 1'b0;
    end

    // Framing flag refreshed at each character
    always_ff @(posedge clk) begin
        if (!rst_n)    frm <= 1'b0;
        else if (done) frm <= !stop_ok;
    end

    // Break flag: re-evaluated per character, set when the threshold is hit
    always_ff @(posedge clk) begin
        if (!rst_n)       brk <= 1'b0;
        else if (done)    brk <= long_low;
        else if (brk_hit) brk <= 1'b1;
    end

    // R3
    // rdy_rise_chk: ready rises only when a character is loaded
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(done));

    // R4
    // rdy_clear_chk: the clear strobe drops ready when nothing completes
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_clr && !done) |=> !rdy);

    // R5
    // ovr_set_chk: completion over an unread character sets overwrite
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy) |=> ovr);

    // R6
    // ovr_sticky_chk: overwrite holds until the write-zero strobe
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_wclr) |=> ovr);

    // R7
    // frm_hold_chk: framing flag is steady between characters
    frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(frm));
endmodule

// File: rtl/uart_rx_flags.sv
// Module: top of the serial receiver with overwrite, framing and break flags.
// Assumes tick16 is a one-cycle pulse at 16 times the bit rate and rx_in
// idles high. Strobes are one-cycle pulses.
module uart_rx_flags #(
    parameter int  DBITS     = 8,
    parameter int  OSR       = 16,
    parameter bit  PARITY_EN = 1'b0,
    parameter int  BRK_TICKS = 168
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rx_in,
    input  logic             rdy_clr,
    input  logic             ovr_wclr,
    output logic [DBITS-1:0] rx_data,
    output logic             rx_rdy,
    output logic             ovr_flag,
    output logic             frm_flag,
    output logic             brk_flag
);
    logic             rx_s;
    logic             done;
    logic [DBITS-1:0] fr_data;
    logic             stop_ok;
    logic             brk_hit;
    logic             long_low;

    uart_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .d_out (rx_s)
    );

    uart_rx_frame #(
        .OSR       (OSR),
        .DBITS     (DBITS),
        .PARITY_EN (PARITY_EN)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rx_s    (rx_s),
        .done    (done),
        .data    (fr_data),
        .stop_ok (stop_ok)
    );

    uart_rx_brk #(
        .BRK_TICKS (BRK_TICKS)
    ) u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx_s     (rx_s),
        .hit      (brk_hit),
        .long_low (long_low)
    );

    uart_rx_stat #(
        .DBITS (DBITS)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .data     (fr_data),
        .stop_ok  (stop_ok),
        .brk_hit  (brk_hit),
        .long_low (long_low),
        .rdy_clr  (rdy_clr),
        .ovr_wclr (ovr_wclr),
        .buf_q    (rx_data),
        .rdy      (rx_rdy),
        .ovr      (ovr_flag),
        .frm      (frm_flag),
        .brk      (brk_flag)
    );
endmodule

// File: tb/uart_rx_flags_tb.sv
// Bench: table of characters walked by one loop, then directed tests for
// reset, start glitch, overwrite, break thresholds and long breaks.
module uart_rx_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic       rdy_clr = 1'b0;
    logic       ovr_wclr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, ovr_flag, frm_flag, brk_flag;
    logic [1:0] tdiv = 2'd0;
    int         total = 0;
    int         bad = 0;

    // Table entries: bit 8 = stop bit level, bits 7:0 = character
    localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h13C, 9'h081,
                                          9'h1FF, 9'h100, 9'h07E};

    uart_rx_flags u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .rdy_clr(rdy_clr), .ovr_wclr(ovr_wclr), .rx_data(rx_data),
        .rx_rdy(rx_rdy), .ovr_flag(ovr_flag), .frm_flag(frm_flag),
        .brk_flag(brk_flag)
    );

    always #4 clk = ~clk;

    // Tick pulse every 4 clocks
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Move to the negedge just after a tick edge
    task automatic align();
        do @(posedge clk); while (!tick16);
        @(negedge clk);
    endtask

    // Hold the line at v for n sampled ticks
    task automatic hold(input logic v, input int n);
        rx_in = v;
        for (int k = 0; k < n; k++) begin
            do @(posedge clk); while (!tick16);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stp);
        align();
        hold(1'b0, 16);
        for (int b = 0; b < 8; b++) hold(d[b], 16);
        hold(stp, 16);
        hold(1'b1, 8);
    endtask

    task automatic pulse_clr();
        @(negedge clk) rdy_clr = 1'b1;
        @(negedge clk) rdy_clr = 1'b0;
    endtask

    task automatic pulse_wclr();
        @(negedge clk) ovr_wclr = 1'b1;
        @(negedge clk) ovr_wclr = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 rdy", rx_rdy, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 frm", frm_flag, 0);
        chk("R1 brk", brk_flag, 0);
        chk("R1 data", rx_data, 0);
        rst_n = 1'b1;
        hold(1'b1, 4);

        // Table walk: R3 data, R7 framing, R9 break clear, R4 clear
        for (int i = 0; i < 6; i++) begin
            send(VEC[i][7:0], VEC[i][8]);
            chk("R3 rdy", rx_rdy, 1);
            chk("R3 data", rx_data, VEC[i][7:0]);
            chk("R7 frm", frm_flag, !VEC[i][8]);
            chk("R9 brk", brk_flag, 0);
            chk("R5 ovr", ovr_flag, 0);
            pulse_clr();
            chk("R4 rdy clr", rx_rdy, 0);
        end

        // R2 8-tick low pulse rejected
        align();
        hold(1'b0, 8);
        hold(1'b1, 200);
        chk("R2 glitch", rx_rdy, 0);
        // R2 9-tick low pulse accepted, data bits read high
        align();
        hold(1'b0, 9);
        hold(1'b1, 200);
        chk("R2 accept rdy", rx_rdy, 1);
        chk("R2 accept data", rx_data, 8'hFF);
        pulse_clr();

        // R5 overwrite, R6 sticky
        send(8'h11, 1'b1);
        chk("R5 no ovr yet", ovr_flag, 0);
        send(8'h22, 1'b1);
        chk("R5 ovr set", ovr_flag, 1);
        chk("R5 data replaced", rx_data, 8'h22);
        pulse_clr();
        send(8'h33, 1'b1);
        chk("R6 ovr sticky", ovr_flag, 1);
        chk("R6 data", rx_data, 8'h33);
        pulse_clr();
        pulse_wclr();
        chk("R6 ovr cleared", ovr_flag, 0);

        // R8 167 ticks low: no break
        align();
        hold(1'b0, 167);
        hold(1'b1, 40);
        chk("R8 167 rdy", rx_rdy, 1);
        chk("R8 167 data", rx_data, 8'h00);
        chk("R7 167 frm", frm_flag, 1);
        chk("R8 167 brk", brk_flag, 0);
        pulse_clr();

        // R8 168 ticks low: break
        align();
        hold(1'b0, 168);
        hold(1'b1, 40);
        chk("R8 168 brk", brk_flag, 1);
        chk("R7 168 frm", frm_flag, 1);
        pulse_clr();

        // R9 normal character clears break, R7 refresh
        send(8'h5A, 1'b1);
        chk("R9 brk cleared", brk_flag, 0);
        chk("R7 frm refreshed", frm_flag, 0);
        chk("R9 data", rx_data, 8'h5A);
        pulse_clr();

        // R10 long break yields one character
        align();
        hold(1'b0, 200);
        pulse_clr();
        align();
        hold(1'b0, 200);
        chk("R10 no second char", rx_rdy, 0);
        chk("R8 long brk", brk_flag, 1);
        hold(1'b1, 40);
        chk("R10 after release", rx_rdy, 0);
        chk("R10 no ovr", ovr_flag, 0);
        send(8'hC3, 1'b1);
        chk("R10 next char", rx_data, 8'hC3);
        chk("R9 brk after long", brk_flag, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule